// File: doc/BRIEF.md
# I2C Slave Byte Memory

This block is a 512-byte memory that answers on a two-wire I2C bus as a slave. It runs on a fast system clock. SCL and SDA are oversampled through synchronizers, and START and STOP are found as an SDA edge while SCL is high. The block only ever pulls SDA low, through an output enable, so it can share an open-drain bus with other devices.

A master selects the device with an address byte. That byte carries a fixed four-bit family code, two bits that must equal the strap inputs, the top address bit, and the read/write flag. This lets four devices with different straps share one bus. A write sets the internal address pointer from the address byte and a following low-address byte. Any further bytes in the same transfer are stored at consecutive locations. A read returns data from the pointer onward. A random read is a write that only sets the pointer, followed by a repeated START and a read. A write-protect input blocks storage but leaves reads untouched.

Top module: `i2cmem_top`

## Requirements
- R1: After reset, SDA is released, the address pointer is 0 and every location reads as 0x00.
- R2: A device address byte is acknowledged only when bits 7..4 are 1010, bit 3 equals `a2_i` and bit 2 equals `a1_i`. On any other byte the block stays silent until the next START, and it neither stores nor returns data.
- R3: In a write transfer, bit 1 of the device address byte is address bit 8 and the next byte gives address bits 7..0. Each following data byte is acknowledged and stored at the pointer.
- R4: The pointer advances by one after every data byte written or read, and it wraps from 511 to 0.
- R5: While `wp_i` is high, written data bytes are still acknowledged and still advance the pointer, but the memory contents do not change.
- R6: In a read transfer, bit 1 of the device address byte is ignored. Data comes from the pointer, most significant bit first, whatever the level of `wp_i`.
- R7: A write of only the two address bytes, then a repeated START and a read address byte, returns data starting at the address that was sent.
- R8: After the master answers a read byte with NACK, the block releases SDA and ends the transfer. A STOP at any point returns it to idle with SDA released.
- R9: The SDA output enable changes only while SCL is low, so the block never creates a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (the wired-AND of all drivers) |
| a1_i | input | 1 | Address strap, compared with address byte bit 2 |
| a2_i | input | 1 | Address strap, compared with address byte bit 3 |
| wp_i | input | 1 | Write protect; high blocks all stores |
| sda_oe_o | output | 1 | High pulls SDA low; low releases it |

## Verification
The bench builds the block with its default parameters: a 9-bit address (512 bytes), family code 1010 and two synchronizer stages. With a 512-byte array, writes and sequential reads that cross the 511-to-0 wrap are cheap to reach. The straps are tied to opposite levels, so an address byte that flips either strap bit is rejected and tests the match for both polarities. A random mix of writes, random reads and current-address reads, with write-protect toggled, runs against a byte-array model that tracks the pointer.

// File: rtl/i2cmem_pkg.sv
package i2cmem_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_ADDR, ST_WDATA, ST_ACK, ST_RDATA, ST_RACK
  } st_e;
endpackage

// File: rtl/i2cmem_sync.sv
module i2cmem_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic sda_o,
  output logic start_o,
  output logic stop_o
);
  localparam int NSIG = 2;
  logic [NSIG-1:0] raw, lvl, prev_q;
  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < NSIG; g++) begin : g_sync
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '1;
      else         chain_q <= {chain_q[STAGES-2:0], raw[g]};
    end
    assign lvl[g] = chain_q[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '1;
    else         prev_q <= lvl;
  end

  assign scl_o      = lvl[0];
  assign sda_o      = lvl[1];
  assign scl_rise_o = lvl[0] & ~prev_q[0];
  assign scl_fall_o = ~lvl[0] & prev_q[0];
  // SDA edges while SCL held high
  assign start_o    = lvl[0] & prev_q[0] & prev_q[1] & ~lvl[1];
  assign stop_o     = lvl[0] & prev_q[0] & ~prev_q[1] & lvl[1];
endmodule

// File: rtl/i2cmem_store.sv
module i2cmem_store #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/i2cmem_ctrl.sv
module i2cmem_ctrl
  import i2cmem_pkg::*;
#(
  parameter int         ADDR_W   = 9,
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              a1_i,
  input  logic              a2_i,
  input  logic              wp_i,
  input  logic [7:0]        rdata_i,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              we_o,
  output logic [7:0]        wdata_o,
  output logic              sda_oe_o
);
  localparam int HI_W = ADDR_W - 8;

  st_e               state_q, nxt_q;
  logic [2:0]        cnt_q;
  logic [7:0]        sh_q, tx_q;
  logic              got_q, oe_q, mack_q;
  logic [HI_W-1:0]   hi_q;
  logic [ADDR_W-1:0] ptr_q;
  logic              dev_match, byte_end, ptr_load;

  assign dev_match = (sh_q[7:4] == DEV_CODE) && (sh_q[3] == a2_i) && (sh_q[2] == a1_i);
  assign byte_end  = scl_fall_i && got_q;
  assign ptr_load  = (state_q == ST_ADDR) && byte_end;
  assign we_o      = (state_q == ST_WDATA) && byte_end && !wp_i;
  assign wdata_o   = sh_q;
  assign ptr_o     = ptr_q;
  assign sda_oe_o  = oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      nxt_q   <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      tx_q    <= '0;
      got_q   <= 1'b0;
      oe_q    <= 1'b0;
      mack_q  <= 1'b0;
      hi_q    <= '0;
      ptr_q   <= '0;
    end else if (start_i) begin
      state_q <= ST_DEV;
      cnt_q   <= '0;
      got_q   <= 1'b0;
      oe_q    <= 1'b0;
    end else if (stop_i) begin
      state_q <= ST_IDLE;
      got_q   <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_DEV, ST_ADDR, ST_WDATA: begin
          if (scl_rise_i) begin
            sh_q  <= {sh_q[6:0], sda_i};
            cnt_q <= cnt_q + 3'd1;
            if (cnt_q == 3'd7) got_q <= 1'b1;
          end else if (byte_end) begin
            got_q <= 1'b0;
            cnt_q <= '0;
            if (state_q == ST_DEV) begin
              if (dev_match) begin
                oe_q    <= 1'b1;
                hi_q    <= sh_q[1 +: HI_W];
                nxt_q   <= sh_q[0] ? ST_RDATA : ST_ADDR;
                state_q <= ST_ACK;
              end else begin
                state_q <= ST_IDLE;
              end
            end else begin
              if (state_q == ST_ADDR) ptr_q <= {hi_q, sh_q};
              else                    ptr_q <= ptr_q + 1'b1;
              oe_q    <= 1'b1;
              nxt_q   <= ST_WDATA;
              state_q <= ST_ACK;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall_i) begin
            cnt_q   <= '0;
            state_q <= nxt_q;
            if (nxt_q == ST_RDATA) begin
              tx_q  <= rdata_i;
              oe_q  <= ~rdata_i[7];
              ptr_q <= ptr_q + 1'b1;
            end else begin
              oe_q  <= 1'b0;
            end
          end
        end
        ST_RDATA: begin
          if (scl_fall_i) begin
            if (cnt_q == 3'd7) begin
              oe_q    <= 1'b0;
              state_q <= ST_RACK;
            end else begin
              cnt_q <= cnt_q + 3'd1;
              tx_q  <= {tx_q[6:0], 1'b0};
              oe_q  <= ~tx_q[6];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise_i) begin
            mack_q <= ~sda_i;
          end else if (scl_fall_i) begin
            if (mack_q) begin
              tx_q    <= rdata_i;
              oe_q    <= ~rdata_i[7];
              ptr_q   <= ptr_q + 1'b1;
              cnt_q   <= '0;
              state_q <= ST_RDATA;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assert_oe_scl_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(oe_q) |-> (!$past(scl_i) || $past(start_i) || $past(stop_i)));

  assert_ptr_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(ptr_q) && !$past(ptr_load)) |-> (ptr_q == $past(ptr_q) + ADDR_W'(1)));

  assert_dev_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DEV) |-> !oe_q);

  assert_rack_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RACK) |-> !oe_q);

  assert_stop_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !start_i) |=> (state_q == ST_IDLE && !oe_q));
endmodule

// File: rtl/i2cmem_top.sv
module i2cmem_top #(
  parameter int         ADDR_W      = 9,
  parameter logic [3:0] DEV_CODE    = 4'b1010,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  input  logic a1_i,
  input  logic a2_i,
  input  logic wp_i,
  output logic sda_oe_o
);
  localparam int DATA_W = 8;

  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev, we;
  logic [ADDR_W-1:0] ptr;
  logic [DATA_W-1:0] wdata, rdata;

  i2cmem_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_i(sda_i),
    .scl_o(scl_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .sda_o(sda_s), .start_o(start_ev), .stop_o(stop_ev)
  );

  i2cmem_ctrl #(.ADDR_W(ADDR_W), .DEV_CODE(DEV_CODE)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_s), .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall), .sda_i(sda_s), .start_i(start_ev), .stop_i(stop_ev),
    .a1_i(a1_i), .a2_i(a2_i), .wp_i(wp_i), .rdata_i(rdata), .ptr_o(ptr),
    .we_o(we), .wdata_o(wdata), .sda_oe_o(sda_oe_o)
  );

  i2cmem_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we), .waddr_i(ptr), .wdata_i(wdata),
    .raddr_i(ptr), .rdata_o(rdata)
  );
endmodule

// File: tb/i2cmem_top_tb.sv
module i2cmem_top_tb;
  localparam int Q = 8;
  localparam int DEPTH = 512;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic a1 = 1'b0, a2 = 1'b1, wp = 1'b0;
  logic sda_oe, sda_bus;
  assign sda_bus = sda_m & ~sda_oe;

  always #2 clk = ~clk;

  i2cmem_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .a1_i(a1), .a2_i(a2), .wp_i(wp), .sda_oe_o(sda_oe)
  );

  int n_chk = 0, n_fail = 0, r9_bad = 0;
  logic [7:0] exp_mem [DEPTH];
  int mptr = 0;
  logic oe_prev = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R9 monitor: enable may only move while SCL is low
  always @(negedge clk) begin
    if (rst_n && sda_oe !== oe_prev && scl_m) r9_bad++;
    oe_prev <= sda_oe;
  end

  function automatic logic [7:0] dev_byte(input logic c2, input logic c1, input logic b8, input logic rw);
    return {4'b1010, c2, c1, b8, rw};
  endfunction

  task automatic hold(input int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start;
    sda_m = 1; hold(Q); scl_m = 1; hold(Q); sda_m = 0; hold(Q); scl_m = 0; hold(Q);
  endtask

  task automatic bus_stop;
    sda_m = 0; hold(Q); scl_m = 1; hold(Q); sda_m = 1; hold(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hold(Q); scl_m = 1; hold(2*Q); scl_m = 0; hold(Q);
    end
    sda_m = 1; hold(Q); scl_m = 1; hold(Q); ack = !sda_bus; hold(Q); scl_m = 0; hold(Q);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1; hold(Q); scl_m = 1; hold(Q); b[i] = sda_bus; hold(Q); scl_m = 0; hold(Q);
    end
    sda_m = give_ack ? 1'b0 : 1'b1; hold(Q); scl_m = 1; hold(2*Q); scl_m = 0; hold(Q);
    sda_m = 1;
  endtask

  task automatic do_write(input int addr, input int n);
    bit ack;
    logic [7:0] d;
    bus_start;
    send_byte(dev_byte(a2, a1, addr[8], 1'b0), ack);
    check(ack, "R2 dev ack (write)", ack, 1);
    send_byte(addr[7:0], ack);
    check(ack, "R3 low address ack", ack, 1);
    mptr = addr;
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      send_byte(d, ack);
      check(ack, wp ? "R5 data ack under wp" : "R3 data ack", ack, 1);
      if (!wp) exp_mem[mptr] = d;
      mptr = (mptr + 1) % DEPTH;
    end
    bus_stop;
  endtask

  task automatic read_body(input int n, input logic b8, input string tag);
    bit ack;
    logic [7:0] d;
    send_byte(dev_byte(a2, a1, b8, 1'b1), ack);
    check(ack, "R2 dev ack (read)", ack, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, d);
      check(d == exp_mem[mptr], tag, d, exp_mem[mptr]);
      mptr = (mptr + 1) % DEPTH;
    end
    check(sda_oe == 1'b0, "R8 released after NACK", sda_oe, 0);
    bus_stop;
  endtask

  task automatic do_rand_read(input int addr, input int n);
    bit ack;
    bus_start;
    send_byte(dev_byte(a2, a1, addr[8], 1'b0), ack);
    check(ack, "R7 dev ack", ack, 1);
    send_byte(addr[7:0], ack);
    check(ack, "R7 address ack", ack, 1);
    mptr = addr;
    bus_start;
    read_body(n, 1'($urandom), "R7 random read data");
  endtask

  task automatic do_cur_read(input int n, input logic b8);
    bus_start;
    read_body(n, b8, "R6 current read data");
  endtask

  task automatic bad_dev(input logic [7:0] db);
    bit ack;
    bus_start;
    send_byte(db, ack);
    check(!ack, "R2 mismatched address not acked", ack, 0);
    send_byte(8'h00, ack);
    check(!ack, "R2 silent until START", ack, 0);
    bus_stop;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) exp_mem[i] = 8'h00;
    void'($urandom(32'h5EED_0042));
    hold(5); rst_n = 1; hold(5);
    check(sda_oe == 1'b0, "R1 SDA released after reset", sda_oe, 0);
    // R1: pointer 0, contents 0
    do_cur_read(3, 1'b0);

    // R3: address bit 8 set through address byte
    do_write(9'h1F0, 3);
    do_rand_read(9'h1F0, 3);

    // R4: wrap on write and read
    do_write(510, 4);
    do_rand_read(510, 4);
    check(mptr == 2, "R4 model pointer after wrap", mptr, 2);
    do_cur_read(2, 1'b0);

    // R5: protected write acked, not stored, pointer advances
    do_write(5, 2);
    wp = 1;
    do_write(5, 2);
    do_cur_read(1, 1'b0);   // R5 pointer moved to 7, R6 read under wp
    wp = 0;
    do_rand_read(5, 2);

    // R2: wrong straps and wrong family code
    bad_dev(dev_byte(~a2, a1, 1'b0, 1'b0));
    bad_dev(dev_byte(a2, ~a1, 1'b0, 1'b1));
    bad_dev({4'b1011, a2, a1, 2'b00});
    do_rand_read(5, 2);

    // R6: bit 1 of read address byte ignored
    do_write(9'h010, 1);
    do_cur_read(1, 1'b1);

    for (int it = 0; it < 30; it++) begin
      int kind, addr, n;
      kind = int'($urandom % 3);
      addr = int'($urandom % DEPTH);
      n    = 1 + int'($urandom % 4);
      wp   = ($urandom % 4) == 0;
      case (kind)
        0: do_write(addr, n);
        1: do_rand_read(addr, n);
        default: do_cur_read(n, 1'($urandom));
      endcase
    end
    wp = 0;
    check(r9_bad == 0, "R9 enable moved while SCL high", r9_bad, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule